// File: doc/BRIEF.md
# Shared Memory Arbiter with Block-Read DMA

This block lets two clients share one single-ported synchronous RAM of 32-bit words. The acquisition client writes words, or reads a word and writes back a modified one, through a request, direction and address interface. The second client is an internal DMA reader. It is loaded with a start address and a word count. After a start pulse it fetches that block in ascending address order and hands each word to a valid/ready output stream. The arbiter serves one access at a time. The acquisition client always wins a tie, so a slow stream consumer cannot hold up measurement traffic.

The arbiter has three states. In `ARB_IDLE` it grants the acquisition request if one is present (transition IDLE→ACQ). Otherwise it grants a DMA request (IDLE→DMA). A grant drives the RAM in that same cycle. In `ARB_ACQ` or `ARB_DMA` the RAM output is ready, and the owner gets a one-cycle acknowledge together with its read data. The arbiter then always returns to `ARB_IDLE` (ACQ→IDLE, DMA→IDLE). An access therefore takes two cycles.

The DMA reader has three states. `DMA_IDLE` moves to `DMA_RUN` on a start pulse. `DMA_RUN` requests a read only while its one-word output buffer is empty and words remain. It moves to `DMA_DONE` when the remaining count reaches zero. `DMA_DONE` moves back to `DMA_RUN` on the next start pulse.

Top module: `mem_arb_dma`

## Requirements
- R1: An acquisition write stores `acq_wdata` at `acq_addr`. An acquisition read returns the stored word on `acq_rdata` in the cycle that `acq_ack` is high. The acknowledge is a one-cycle pulse that comes in the cycle after the access is granted.
- R2: When both clients request in the same idle cycle, the acquisition access is served first. While acquisition requests keep arriving back to back, no DMA word is produced.
- R3: Only one access is served at a time. An acknowledge goes only to a client that was requesting in the previous cycle.
- R4: After a start, the DMA reader emits exactly `dma_count` words. These are the words at `dma_base`, `dma_base+1` and onward, wrapping modulo 2^AW, in that order.
- R5: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values. No new DMA read is issued while the output buffer is full.
- R6: `dma_done` rises after the last word of the block has been read, and it is cleared by the next start. A start that arrives while a block is still running is ignored.
- R7: A start with `dma_count` equal to zero emits no word and raises `dma_done` again.
- R8: After reset, `acq_ack`, `out_valid` and `dma_done` are low.
- R9: Acquisition read-modify-write sequences give correct results while the DMA reader is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | 1 | Acquisition access request, held until acknowledged |
| acq_we | input | 1 | Acquisition direction: 1 write, 0 read |
| acq_addr | input | AW | Acquisition word address |
| acq_wdata | input | 32 | Acquisition write data |
| acq_ack | output | 1 | One-cycle acknowledge of an acquisition access |
| acq_rdata | output | 32 | Acquisition read data, valid with `acq_ack` |
| dma_start | input | 1 | Start pulse for a block read |
| dma_base | input | AW | Block start address, captured on start |
| dma_count | input | CW | Block length in words, captured on start |
| dma_done | output | 1 | Block finished |
| out_valid | output | 1 | Stream word available |
| out_ready | input | 1 | Stream consumer accepts the word |
| out_data | output | 32 | Stream word |

## Verification
The bench builds the block with AW=6 and CW=7. The whole 64-word memory can then be written and read back exhaustively, and a block of the full memory size is legal. Block reads are swept over several base addresses, including ones near the top so that the address wraps. Counts of 0, 1, short, half-memory and full-memory are used. The stream is drained under a ready pattern that stalls the consumer. The small memory also lets the bench use the DMA against read-modify-write traffic on a disjoint address range, and saturate the port with back-to-back acquisition reads to show that the stream starves.

// File: rtl/mad_pkg.sv
package mad_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_ACQ  = 2'd1,
        ARB_DMA  = 2'd2
    } arb_state_t;

    typedef enum logic [1:0] {
        DMA_IDLE = 2'd0,
        DMA_RUN  = 2'd1,
        DMA_DONE = 2'd2
    } dma_state_t;
endpackage

// File: rtl/mad_ram.sv
module mad_ram
    import mad_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  word_t         wdata,
    output word_t         rdata
);
    localparam int DEPTH = 1 << AW;

    word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                store[addr] <= wdata;
            end
            rdata <= store[addr];
        end
    end
endmodule

// File: rtl/mad_arbiter.sv
module mad_arbiter
    import mad_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_req,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  word_t         a_wdata,
    output logic          a_ack,
    input  logic          d_req,
    input  logic [AW-1:0] d_addr,
    output logic          d_ack,
    output logic          m_en,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output word_t         m_wdata
);
    arb_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ARB_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ARB_IDLE;
        m_en     = 1'b0;
        m_we     = 1'b0;
        m_addr   = a_addr;
        m_wdata  = a_wdata;
        a_ack    = 1'b0;
        d_ack    = 1'b0;
        unique case (state)
            ARB_IDLE: begin
                if (a_req) begin
                    m_en     = 1'b1;
                    m_we     = a_we;
                    state_nx = ARB_ACQ;
                end else if (d_req) begin
                    m_en     = 1'b1;
                    m_addr   = d_addr;
                    state_nx = ARB_DMA;
                end
            end
            ARB_ACQ: a_ack = 1'b1;
            ARB_DMA: d_ack = 1'b1;
            default: state_nx = ARB_IDLE;
        endcase
    end

    // R3
    ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_ack && d_ack));
    // R3
    acq_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_ack |-> $past(a_req));
    // R3
    dma_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_ack |-> $past(d_req));
    // R2
    acq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && a_req && d_req) |=> (a_ack && !d_ack));
endmodule

// File: rtl/mad_dma.sv
module mad_dma
    import mad_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    output logic          done,
    output logic          req,
    output logic [AW-1:0] addr,
    input  logic          ack,
    input  word_t         rdata,
    output logic          o_valid,
    input  logic          o_ready,
    output word_t         o_data
);
    dma_state_t state, state_nx;
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DMA_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DMA_IDLE: if (start) state_nx = DMA_RUN;
            DMA_RUN:  if (left == '0 || (ack && left == CW'(1))) state_nx = DMA_DONE;
            DMA_DONE: if (start) state_nx = DMA_RUN;
            default:  state_nx = DMA_IDLE;
        endcase
    end

    assign done = (state == DMA_DONE);
    assign req  = (state == DMA_RUN) && !o_valid && (left != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left    <= '0;
            addr    <= '0;
            o_valid <= 1'b0;
            o_data  <= '0;
        end else begin
            if (start && state != DMA_RUN) begin
                left <= count;
                addr <= base;
            end else if (ack) begin
                left <= left - CW'(1);
                addr <= addr + AW'(1);
            end
            if (ack) begin
                o_valid <= 1'b1;
                o_data  <= rdata;
            end else if (o_ready) begin
                o_valid <= 1'b0;
            end
        end
    end

    // R5
    hold_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));
    // R5
    no_read_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !$past(o_valid));
    // R6
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (left == '0));
    // R6
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);
endmodule

// File: rtl/mem_arb_dma.sv
module mem_arb_dma
    import mad_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq_req,
    input  logic          acq_we,
    input  logic [AW-1:0] acq_addr,
    input  logic [31:0]   acq_wdata,
    output logic          acq_ack,
    output logic [31:0]   acq_rdata,
    input  logic          dma_start,
    input  logic [AW-1:0] dma_base,
    input  logic [CW-1:0] dma_count,
    output logic          dma_done,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [31:0]   out_data
);
    logic          d_req, d_ack, m_en, m_we;
    logic [AW-1:0] d_addr, m_addr;
    word_t         m_wdata, m_rdata;

    mad_arbiter #(.AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .a_req(acq_req), .a_we(acq_we), .a_addr(acq_addr), .a_wdata(acq_wdata),
        .a_ack(acq_ack),
        .d_req(d_req), .d_addr(d_addr), .d_ack(d_ack),
        .m_en(m_en), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata)
    );

    mad_dma #(.AW(AW), .CW(CW)) u_dma (
        .clk(clk), .rst_n(rst_n),
        .start(dma_start), .base(dma_base), .count(dma_count), .done(dma_done),
        .req(d_req), .addr(d_addr), .ack(d_ack), .rdata(m_rdata),
        .o_valid(out_valid), .o_ready(out_ready), .o_data(out_data)
    );

    mad_ram #(.AW(AW)) u_ram (
        .clk(clk), .en(m_en), .we(m_we), .addr(m_addr),
        .wdata(m_wdata), .rdata(m_rdata)
    );

    assign acq_rdata = m_rdata;

    // R1
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_ack |=> !acq_ack);
endmodule

// File: tb/sim_mem_arb_dma.sv
`timescale 1ns/1ps
module sim_mem_arb_dma;
    localparam int AW = 6;
    localparam int CW = 7;
    localparam int N  = 1 << AW;

    logic clk = 0, rst_n = 0;
    logic acq_req = 0, acq_we = 0;
    logic [AW-1:0] acq_addr = '0;
    logic [31:0] acq_wdata = '0;
    logic acq_ack;
    logic [31:0] acq_rdata;
    logic dma_start = 0;
    logic [AW-1:0] dma_base = '0;
    logic [CW-1:0] dma_count = '0;
    logic dma_done, out_valid, out_ready = 0;
    logic [31:0] out_data;

    int vectors = 0, errors = 0, cyc = 0;
    logic [31:0] model [N];

    always #5 clk = ~clk;

    mem_arb_dma #(.AW(AW), .CW(CW)) u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int a);
        return (32'(a) * 32'h0103_0507) ^ 32'hA55A_0000;
    endfunction

    task automatic acq_op(input logic we, input int a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        acq_req = 1; acq_we = we; acq_addr = AW'(a); acq_wdata = d;
        do @(negedge clk); while (!acq_ack);
        rd = acq_rdata;
        acq_req = 0;
        if (we) model[a] = d;
    endtask

    // drain a DMA block, checking order, stalls and done
    task automatic dma_run(input int base, input int cnt, input bit retry_start);
        int got = 0;
        logic pv = 0; logic [31:0] pd = '0;
        int k = 0;
        @(negedge clk);
        dma_base = AW'(base); dma_count = CW'(cnt); dma_start = 1;
        @(negedge clk);
        dma_start = 0;
        chk("R6 done cleared by start", {31'd0, dma_done}, 32'd0);
        while (!(dma_done && !out_valid)) begin
            k++;
            out_ready = (k % 3) != 0;
            if (retry_start && k == 4) begin
                dma_base = AW'(base + 17); dma_count = CW'(1); dma_start = 1;
            end else dma_start = 0;
            if (pv) chk("R5 word held under stall", out_data, pd);
            if (out_valid && out_ready) begin
                if (got < cnt)
                    chk("R4 block word order", out_data, model[(base + got) % N]);
                got++;
            end
            pv = out_valid && !out_ready; pd = out_data;
            @(negedge clk);
        end
        dma_start = 0; out_ready = 0;
        chk("R4 R7 word count", 32'(got), 32'(cnt));
        chk("R6 done after block", {31'd0, dma_done}, 32'd1);
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        chk("R8 acq_ack reset", {31'd0, acq_ack}, 0);
        chk("R8 out_valid reset", {31'd0, out_valid}, 0);
        chk("R8 dma_done reset", {31'd0, dma_done}, 0);
        rst_n = 1;

        // R1 exhaustive write then read back
        for (int a = 0; a < N; a++) acq_op(1, a, pat(a), rd);
        for (int a = 0; a < N; a++) begin
            acq_op(0, a, 0, rd);
            chk("R1 read back", rd, pat(a));
        end

        // R4 R7 sweeps including wrap
        dma_run(0, 1, 0);
        dma_run(5, 3, 0);
        dma_run(60, 8, 0);
        dma_run(0, 0, 0);
        dma_run(33, 64, 0);
        // R6 start while running is ignored
        dma_run(10, 20, 1);

        // R9 RMW on 40..47 concurrent with DMA over 0..31
        fork
            dma_run(0, 32, 0);
            begin
                for (int r = 0; r < 3; r++)
                    for (int a = 40; a < 48; a++) begin
                        acq_op(0, a, 0, rd);
                        chk("R9 rmw read", rd, model[a]);
                        acq_op(1, a, rd + 32'd1, rd);
                    end
            end
        join
        for (int a = 40; a < 48; a++) begin
            acq_op(0, a, 0, rd);
            chk("R9 rmw result", rd, pat(a) + 32'd3);
        end

        // R2 back-to-back acquisition reads starve DMA
        @(negedge clk);
        dma_base = 0; dma_count = 4; dma_start = 1;
        acq_req = 1; acq_we = 0; acq_addr = 3;
        @(negedge clk);
        dma_start = 0; out_ready = 1;
        begin
            int seen = 0;
            for (int i = 0; i < 40; i++) begin
                if (out_valid) seen++;
                @(negedge clk);
            end
            chk("R2 no DMA word while acq saturates", 32'(seen), 0);
        end
        acq_req = 0;
        begin
            int w = 0;
            for (int i = 0; i < 60; i++) begin
                if (out_valid) begin
                    chk("R2 DMA proceeds after release", out_data, model[w]);
                    w++;
                end
                @(negedge clk);
            end
            chk("R2 DMA word count after release", 32'(w), 4);
        end
        out_ready = 0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule